// File: doc/BRIEF.md
# Return Address Stack Predictor

This block supplies predicted targets for subroutine returns at the fetch stage of a processor front end. Another unit marks each fetched instruction as a call, a return, or neither. On a call, the block stores the address of the next sequential instruction, which is the fetch PC plus the instruction size in bytes. On a return, the block removes the most recent stored address and presents it as the predicted next fetch address for that cycle. A flush from the back end empties the stack.

The storage is a ring of a fixed number of entries, eight by default. A stack that is already full does not stall when it gets another call. The new address overwrites the oldest entry. A return that arrives while the stack is empty gives no prediction, and the pointer does not move.

The prediction is combinational from the registered top entry. It is valid in the same cycle as the return flag. Stack updates take effect at the following clock edge.

Top module: `ras_predictor`

## Requirements
- R1: After reset the stack is empty, so a return flagged in the first cycle produces `pred_valid_o` = 0.
- R2: A call, flagged without a return or flush, pushes `fetch_pc_i + insn_size_i`. A later return with no intervening stack activity predicts exactly that address with `pred_valid_o` = 1 in the cycle of the return.
- R3: Nested calls are returned in last-in first-out order.
- R4: With DEPTH entries, the occupancy never exceeds DEPTH. After DEPTH+k calls, the next DEPTH returns give the most recent DEPTH addresses, newest first, and the return after those is not valid.
- R5: A return on an empty stack gives `pred_valid_o` = 0 and leaves the occupancy at zero and the top pointer unchanged. Later calls and returns still behave normally.
- R6: When a call and a return are flagged together on a non-empty stack, the return is served first. The prediction is the old top entry. The call's address then replaces that entry, and the occupancy stays the same.
- R7: When a call and a return are flagged together on an empty stack, no prediction is made and the call's address is pushed, giving an occupancy of one.
- R8: `flush_i` empties the stack at the next edge. It takes priority over call and return flags in the same cycle: no prediction is made and nothing is pushed.
- R9: `pred_valid_o` is 1 only in a cycle where `ret_i` is 1.
- R10: The pushed address is computed modulo 2^AW, so a call near the top of the address space wraps around to low addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Empty the stack |
| call_i | input | 1 | Fetched instruction is a call |
| ret_i | input | 1 | Fetched instruction is a return |
| fetch_pc_i | input | AW (32) | Address of the fetched instruction |
| insn_size_i | input | SW (3) | Size of the fetched instruction in bytes |
| pred_valid_o | output | 1 | Predicted return target is valid this cycle |
| pred_target_o | output | AW (32) | Predicted return target |

## Verification
A call and a return can be flagged in the same cycle. The bench does this once on a stack holding two entries and once on an empty stack. In the first case it checks that the prediction is the entry pushed before that cycle. It then drains the stack and checks that the simultaneous call replaced the top entry and left the entry below it in place. In the empty case it checks that no prediction appears and that the next return gets the simultaneous call's address. Flush combined with a simultaneous call and return is also driven, and the bench checks that nothing is pushed.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_SWAP,
        OP_CLEAR
    } ras_op_e;

    // Flush dominates; call and return together form a swap.
    function automatic ras_op_e ras_decode(input logic flush, input logic call,
                                           input logic ret);
        ras_op_e op;
        if (flush)             op = OP_CLEAR;
        else if (call && ret)  op = OP_SWAP;
        else if (call)         op = OP_PUSH;
        else if (ret)          op = OP_POP;
        else                   op = OP_IDLE;
        return op;
    endfunction

endpackage

// File: rtl/ras_link_addr.sv
module ras_link_addr #(
    parameter int AW = 32,
    parameter int SW = 3
) (
    input  logic [AW-1:0] pc_i,
    input  logic [SW-1:0] size_i,
    output logic [AW-1:0] link_o
);

    logic [AW-1:0] size_ext;

    always_comb begin
        size_ext = '0;
        size_ext[SW-1:0] = size_i;
        link_o = pc_i + size_ext;
    end

endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ras_op_e          op_i,
    output logic             pred_valid_o,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o,
    output logic [PTR_W-1:0] top_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] top;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
        return (p == '0) ? LAST_IDX : p - PTR_W'(1);
    endfunction

    logic empty;

    always_comb begin
        ctl_d        = ctl_q;
        empty        = (ctl_q.cnt == '0);
        pred_valid_o = 1'b0;
        wr_en_o      = 1'b0;
        wr_idx_o     = ptr_inc(ctl_q.top);
        unique case (op_i)
            OP_PUSH: begin
                wr_en_o   = 1'b1;
                ctl_d.top = ptr_inc(ctl_q.top);
                ctl_d.cnt = (ctl_q.cnt == FULL_CNT) ? ctl_q.cnt : ctl_q.cnt + CNT_W'(1);
            end
            OP_POP: begin
                if (!empty) begin
                    pred_valid_o = 1'b1;
                    ctl_d.top    = ptr_dec(ctl_q.top);
                    ctl_d.cnt    = ctl_q.cnt - CNT_W'(1);
                end
            end
            OP_SWAP: begin
                wr_en_o = 1'b1;
                if (!empty) begin
                    // pop then push lands on the same slot
                    pred_valid_o = 1'b1;
                    wr_idx_o     = ctl_q.top;
                end else begin
                    ctl_d.top = ptr_inc(ctl_q.top);
                    ctl_d.cnt = CNT_W'(1);
                end
            end
            OP_CLEAR: begin
                ctl_d.cnt = '0;
            end
            default: begin
                ctl_d = ctl_q;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_idx_o = ctl_q.top;
    assign top_o    = ctl_q.top;
    assign cnt_o    = ctl_q.cnt;

endmodule

// File: rtl/ras_entry_file.sv
module ras_entry_file #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [PTR_W-1:0] wr_idx_i,
    input  logic [AW-1:0]    wr_data_i,
    input  logic [PTR_W-1:0] rd_idx_i,
    output logic [AW-1:0]    rd_data_o
);

    logic [AW-1:0] ent_d [DEPTH];
    logic [AW-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            ent_d[g] = ent_q[g];
            if (wr_en_i && (wr_idx_i == PTR_W'(g))) begin
                ent_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else begin
                ent_q[g] <= ent_d[g];
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx_i == PTR_W'(i)) begin
                rd_data_o = ent_q[i];
            end
        end
    end

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int SW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic [AW-1:0] fetch_pc_i,
    input  logic [SW-1:0] insn_size_i,
    output logic          pred_valid_o,
    output logic [AW-1:0] pred_target_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    ras_op_e          op;
    logic [AW-1:0]    link_addr;
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic [PTR_W-1:0] top_ptr;
    logic [CNT_W-1:0] occ_cnt;
    logic [AW-1:0]    top_entry;

    assign op = ras_decode(flush_i, call_i, ret_i);

    ras_link_addr #(.AW(AW), .SW(SW)) u_link (
        .pc_i   (fetch_pc_i),
        .size_i (insn_size_i),
        .link_o (link_addr)
    );

    ras_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_i         (op),
        .pred_valid_o (pred_valid_o),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .rd_idx_o     (rd_idx),
        .top_o        (top_ptr),
        .cnt_o        (occ_cnt)
    );

    ras_entry_file #(.DEPTH(DEPTH), .AW(AW), .PTR_W(PTR_W)) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (link_addr),
        .rd_idx_i  (rd_idx),
        .rd_data_o (top_entry)
    );

    assign pred_target_o = top_entry;

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int PTR_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             call_i,
    input logic             ret_i,
    input logic             pred_valid_o,
    input logic [AW-1:0]    link_addr,
    input logic [AW-1:0]    top_entry,
    input logic [PTR_W-1:0] top_ptr,
    input logic [CNT_W-1:0] occ_cnt
);

    // R9
    valid_needs_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o |-> ret_i);

    // R8
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (occ_cnt == '0));

    // R4
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt <= CNT_W'(DEPTH));

    // R2
    push_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !flush_i) |=> (top_entry == $past(link_addr)));

    // R5
    empty_pop_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !flush_i && occ_cnt == '0)
        |=> (occ_cnt == '0) && $stable(top_ptr));

    // R6
    swap_keeps_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && call_i && !flush_i && occ_cnt != '0)
        |=> $stable(occ_cnt) && $stable(top_ptr) && (top_entry == $past(link_addr)));

    // R7
    swap_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && call_i && !flush_i && occ_cnt == '0)
        |=> (occ_cnt == CNT_W'(1)) && !$past(pred_valid_o));

endmodule

bind ras_predictor ras_chk #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_i      (flush_i),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .pred_valid_o (pred_valid_o),
    .link_addr    (link_addr),
    .top_entry    (top_entry),
    .top_ptr      (top_ptr),
    .occ_cnt      (occ_cnt)
);

// File: tb/tb_ras_predictor.sv
module tb_ras_predictor;

    localparam int AW = 32;
    localparam int SW = 3;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          call_i = 1'b0;
    logic          ret_i = 1'b0;
    logic [AW-1:0] fetch_pc_i = '0;
    logic [SW-1:0] insn_size_i = '0;
    logic          pred_valid_o;
    logic [AW-1:0] pred_target_o;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    ras_predictor #(.DEPTH(DEPTH), .AW(AW), .SW(SW)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .call_i        (call_i),
        .ret_i         (ret_i),
        .fetch_pc_i    (fetch_pc_i),
        .insn_size_i   (insn_size_i),
        .pred_valid_o  (pred_valid_o),
        .pred_target_o (pred_target_o)
    );

    // One fetch cycle: drive at negedge, sample before the next posedge.
    task automatic cyc(input logic f, input logic c, input logic r,
                       input logic [AW-1:0] pc, input logic [SW-1:0] sz,
                       output logic v, output logic [AW-1:0] t);
        @(negedge clk);
        flush_i = f; call_i = c; ret_i = r;
        fetch_pc_i = pc; insn_size_i = sz;
        #1;
        v = pred_valid_o;
        t = pred_target_o;
    endtask

    task automatic check(input string req, input logic v, input logic [AW-1:0] t,
                         input logic ev, input logic [AW-1:0] et);
        total++;
        if (v !== ev || (ev && t !== et)) begin
            bad++;
            $display("FAIL %s: valid=%0b target=%h expected valid=%0b target=%h",
                     req, v, t, ev, et);
        end
    endtask

    task automatic do_call(input logic [AW-1:0] pc, input logic [SW-1:0] sz);
        logic v; logic [AW-1:0] t;
        cyc(1'b0, 1'b1, 1'b0, pc, sz, v, t);
        check("R9 call only", v, t, 1'b0, '0);
    endtask

    task automatic do_ret(input string req, input logic ev, input logic [AW-1:0] et);
        logic v; logic [AW-1:0] t;
        cyc(1'b0, 1'b0, 1'b1, '0, '0, v, t);
        check(req, v, t, ev, et);
    endtask

    task automatic idle;
        logic v; logic [AW-1:0] t;
        cyc(1'b0, 1'b0, 1'b0, '0, '0, v, t);
    endtask

    task automatic t_reset;
        logic v; logic [AW-1:0] t;
        cyc(1'b0, 1'b0, 1'b0, 32'h10, 3'd4, v, t);
        check("R9 idle", v, t, 1'b0, '0);
        do_ret("R1 empty after reset", 1'b0, '0);
    endtask

    task automatic t_push_pop;
        do_call(32'h0000_1000, 3'd4);
        do_ret("R2 single return", 1'b1, 32'h0000_1004);
        do_ret("R5 drained", 1'b0, '0);
    endtask

    task automatic t_nested;
        do_call(32'h0000_0100, 3'd2);
        do_call(32'h0000_0200, 3'd4);
        do_call(32'h0000_0300, 3'd4);
        do_ret("R3 nest 3", 1'b1, 32'h0000_0304);
        do_ret("R3 nest 2", 1'b1, 32'h0000_0204);
        do_ret("R3 nest 1", 1'b1, 32'h0000_0102);
        do_ret("R3 nest empty", 1'b0, '0);
    endtask

    task automatic t_overflow;
        for (int i = 0; i < DEPTH + 2; i++) begin
            do_call(32'h0000_4000 + 32'(i * 16), 3'd4);
        end
        for (int i = DEPTH + 1; i >= 2; i--) begin
            do_ret("R4 overflow order", 1'b1, 32'h0000_4004 + 32'(i * 16));
        end
        do_ret("R4 oldest lost", 1'b0, '0);
    endtask

    task automatic t_underflow;
        do_ret("R5 empty pop", 1'b0, '0);
        do_ret("R5 empty pop twice", 1'b0, '0);
        do_call(32'h0000_5000, 3'd4);
        do_call(32'h0000_5100, 3'd2);
        do_ret("R5 after underflow top", 1'b1, 32'h0000_5102);
        do_ret("R5 after underflow next", 1'b1, 32'h0000_5004);
        do_ret("R5 drained again", 1'b0, '0);
    endtask

    task automatic t_same_cycle;
        logic v; logic [AW-1:0] t;
        do_call(32'h0000_6000, 3'd4);
        do_call(32'h0000_7000, 3'd2);
        cyc(1'b0, 1'b1, 1'b1, 32'h0000_8000, 3'd4, v, t);
        check("R6 swap predicts old top", v, t, 1'b1, 32'h0000_7002);
        do_ret("R6 swap replaced top", 1'b1, 32'h0000_8004);
        do_ret("R6 lower entry kept", 1'b1, 32'h0000_6004);
        do_ret("R6 depth unchanged", 1'b0, '0);
    endtask

    task automatic t_same_empty;
        logic v; logic [AW-1:0] t;
        cyc(1'b0, 1'b1, 1'b1, 32'h0000_9000, 3'd4, v, t);
        check("R7 swap on empty", v, t, 1'b0, '0);
        do_ret("R7 pushed", 1'b1, 32'h0000_9004);
        do_ret("R7 only one", 1'b0, '0);
    endtask

    task automatic t_flush;
        logic v; logic [AW-1:0] t;
        do_call(32'h0000_A000, 3'd4);
        do_call(32'h0000_A100, 3'd4);
        cyc(1'b1, 1'b0, 1'b0, '0, '0, v, t);
        check("R8 flush cycle", v, t, 1'b0, '0);
        do_ret("R8 empty after flush", 1'b0, '0);
        do_call(32'h0000_B000, 3'd4);
        cyc(1'b1, 1'b1, 1'b1, 32'h0000_C000, 3'd4, v, t);
        check("R8 flush beats return", v, t, 1'b0, '0);
        do_ret("R8 flush beats call", 1'b0, '0);
    endtask

    task automatic t_wrap;
        do_call(32'hFFFF_FFFE, 3'd4);
        do_ret("R10 address wrap", 1'b1, 32'h0000_0002);
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL R1 watchdog expired: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_push_pop();
        t_nested();
        t_overflow();
        t_underflow();
        t_same_cycle();
        t_same_empty();
        t_flush();
        t_wrap();
        idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule